// File: doc/BRIEF.md
# HDLC Transmit Chunk Feeder

This block moves one outgoing frame from an upstream byte buffer into a 32-byte HDLC transmit FIFO. It reads the buffer through a plain address/data pair and writes one byte per clock into the FIFO. The frame is sent in chunks of up to 32 bytes. After each chunk it raises a single-cycle command strobe. The command code tells the transmitter either to keep sending or that this chunk closes the message. Bit stuffing, flags and CRC belong to the transmitter behind the FIFO.

The transmitter drives the flow back through event pulses. A pool-ready pulse says the FIFO has room again, and the feeder then loads the next chunk or, once nothing is left, pulses a completion confirm. An underrun pulse or a repeat-request pulse sends the feeder back to the first byte of the frame, so the whole frame goes out again. The feeder accepts frame requests only while the line reports the active state. It also issues a combined transmitter-and-receiver reset command once after reset.

Top module: `hdlc_tx_feeder`

## Requirements
- R1: In the first cycle after `rst` falls, `cmd_valid` is high with `cmd_code` 0x41 (transmitter reset 0x01 plus receiver reset 0x40), and `req_ready` is low. No other command or FIFO write comes before the first request.
- R2: `req_ready` is high only while no frame is in progress. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. A request made while a frame is in progress is refused and has no effect on that frame.
- R3: A request taken while `line_active` is low is dropped. No FIFO write, no command and no confirm follow it, and `req_ready` stays high.
- R4: Valid lengths run from 1 to MAX_LEN (300). A request with length 0, or with a length above MAX_LEN, is dropped in the same way as in R3.
- R5: Bytes are written one per cycle with `fifo_wr`, in buffer order starting at address 0. A chunk holds the smaller of 32 and the number of bytes still unsent. The first chunk starts in the cycle after the request is taken.
- R6: In the cycle after the last byte of a chunk, one command pulse is issued. Its code is 0x08 (continue) if bytes are left after the chunk. Its code is 0x0A (continue with message end, bit 1 set) if the chunk finishes the frame, and this includes a chunk of exactly 32 bytes that ends the frame.
- R7: A `pool_ready` pulse while the feeder waits after a chunk, with bytes left, starts the next chunk in the following cycle.
- R8: A `pool_ready` pulse while the feeder waits after the final chunk raises `confirm` for exactly one cycle in the next cycle, and `req_ready` returns high.
- R9: An `underrun` or `repeat_req` pulse while the feeder waits after a chunk sets the frame back to byte 0 and clears the sent count, even after the final chunk. The next `pool_ready` then resends the frame from its first byte. If a rewind pulse and `pool_ready` arrive in the same cycle, the rewind takes effect first.
- R10: `pool_ready`, `underrun` and `repeat_req` pulses while no frame is in progress are ignored. They cause no FIFO write, no command and no confirm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_active | input | 1 | Line is in the active state; frames may start |
| req_valid | input | 1 | Frame request |
| req_len | input | LEN_W (9) | Frame length in bytes |
| req_ready | output | 1 | Feeder idle, request can be taken |
| buf_addr | output | LEN_W (9) | Read address into the upstream frame buffer |
| buf_data | input | DATA_W (8) | Buffer byte at `buf_addr` (combinational read) |
| pool_ready | input | 1 | Transmit FIFO space available event |
| underrun | input | 1 | Transmit underrun event |
| repeat_req | input | 1 | Transmitter asks for the frame to be repeated |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | DATA_W (8) | FIFO write byte |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 8 | Command code |
| confirm | output | 1 | Frame completion pulse |

## Verification
The bench runs frame lengths on both sides of the 32-byte boundary (1, 32, 33, 64, 300). A feeder that got the boundary test wrong would send 0x08 on a final chunk of exactly 32 bytes, or split 33 bytes into chunks of the wrong size. Rewinds are applied after a middle chunk, after the final chunk, and in the same cycle as a pool-ready pulse. A feeder that rewound by the wrong amount, or let the pool-ready event win, would resend from the middle of the frame. The bench also sends requests while the line is down, with lengths 0 and 301, and while a frame is in progress. A design that let any of these through would write extra bytes or change the frame being sent. Stray events while idle check that the feeder writes nothing and raises no confirm before a frame exists.

// File: rtl/hdlc_txf_pkg.sv
package hdlc_txf_pkg;

    localparam logic [7:0] CMD_XMIT_CONT  = 8'h08;
    localparam logic [7:0] CMD_MSG_END    = 8'h02;
    localparam logic [7:0] CMD_XMIT_RESET = 8'h01;
    localparam logic [7:0] CMD_RECV_RESET = 8'h40;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_LOAD,
        ST_ISSUE,
        ST_WAIT
    } feed_state_e;

    typedef struct packed {
        logic init;
        logic chunk;
        logic ends_frame;
    } cmd_req_t;

    function automatic logic [7:0] chunk_cmd(input logic ends_frame);
        return ends_frame ? (CMD_XMIT_CONT | CMD_MSG_END) : CMD_XMIT_CONT;
    endfunction

    function automatic logic [7:0] reset_cmd();
        return CMD_XMIT_RESET | CMD_RECV_RESET;
    endfunction

endpackage

// File: rtl/txf_pointer.sv
module txf_pointer #(
    parameter int LEN_W = 9,
    parameter int CHUNK = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             rewind,
    input  logic             step,
    output logic [LEN_W-1:0] rd_ptr,
    output logic             chunk_last,
    output logic             frame_last,
    output logic             more_left
);
    localparam int CNT_W = (CHUNK > 1) ? $clog2(CHUNK) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CHUNK - 1);

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] ptr_q;
    logic [CNT_W-1:0] in_chunk_q;

    // ptr_q counts the bytes already handed over, so it doubles as the sent count
    assign frame_last = ({1'b0, ptr_q} + 1'b1) == {1'b0, len_q};
    assign chunk_last = (in_chunk_q == CNT_TOP) || frame_last;
    assign more_left  = ptr_q != len_q;
    assign rd_ptr     = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q      <= '0;
            ptr_q      <= '0;
            in_chunk_q <= '0;
        end else if (start) begin
            len_q      <= frame_len;
            ptr_q      <= '0;
            in_chunk_q <= '0;
        end else begin
            if (rewind) begin
                ptr_q      <= '0;
                in_chunk_q <= '0;
            end
            if (step) begin
                ptr_q      <= ptr_q + 1'b1;
                in_chunk_q <= chunk_last ? '0 : in_chunk_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/txf_sequencer.sv
module txf_sequencer
    import hdlc_txf_pkg::*;
#(
    parameter int LEN_W   = 9,
    parameter int MAX_LEN = 300
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    input  logic             line_active,
    input  logic             pool_ready,
    input  logic             underrun,
    input  logic             repeat_req,
    input  logic             chunk_last,
    input  logic             frame_last,
    input  logic             more_left,
    output logic             req_ready,
    output logic             start,
    output logic             step,
    output logic             rewind,
    output cmd_req_t         cmd_req,
    output logic             confirm
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

    feed_state_e state_q, state_d;
    logic        ends_q;
    logic        confirm_q;
    logic        len_ok;
    logic        waiting;
    logic        done_now;

    assign waiting  = state_q == ST_WAIT;
    assign len_ok   = (req_len != '0) && (req_len <= LEN_MAX);
    assign rewind   = waiting && (underrun || repeat_req);
    assign start    = (state_q == ST_IDLE) && req_valid && line_active && len_ok;
    assign step     = state_q == ST_LOAD;
    // a rewind in the same cycle always leaves bytes to send
    assign done_now = waiting && pool_ready && !rewind && !more_left;

    assign req_ready          = state_q == ST_IDLE;
    assign confirm            = confirm_q;
    assign cmd_req.init       = (state_q == ST_INIT) && !rst;
    assign cmd_req.chunk      = state_q == ST_ISSUE;
    assign cmd_req.ends_frame = ends_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_INIT:  state_d = ST_IDLE;
            ST_IDLE:  if (start) state_d = ST_LOAD;
            ST_LOAD:  if (chunk_last) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (pool_ready) state_d = (rewind || more_left) ? ST_LOAD : ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_INIT;
            ends_q    <= 1'b0;
            confirm_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            confirm_q <= done_now;
            if (step && chunk_last) ends_q <= frame_last;
        end
    end

endmodule

// File: rtl/txf_cmd_encoder.sv
module txf_cmd_encoder
    import hdlc_txf_pkg::*;
(
    input  cmd_req_t   cmd_req,
    output logic       cmd_valid,
    output logic [7:0] cmd_code
);
    always_comb begin
        cmd_valid = cmd_req.init || cmd_req.chunk;
        if (cmd_req.init)       cmd_code = reset_cmd();
        else if (cmd_req.chunk) cmd_code = chunk_cmd(cmd_req.ends_frame);
        else                    cmd_code = 8'h00;
    end

endmodule

// File: rtl/hdlc_tx_feeder.sv
module hdlc_tx_feeder
    import hdlc_txf_pkg::*;
#(
    parameter int CHUNK   = 32,
    parameter int MAX_LEN = 300,
    parameter int DATA_W  = 8,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_active,
    input  logic              req_valid,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    output logic [LEN_W-1:0]  buf_addr,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              pool_ready,
    input  logic              underrun,
    input  logic              repeat_req,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data,
    output logic              cmd_valid,
    output logic [7:0]        cmd_code,
    output logic              confirm
);
    logic     start;
    logic     step;
    logic     rewind;
    logic     chunk_last;
    logic     frame_last;
    logic     more_left;
    cmd_req_t cmd_req;

    txf_pointer #(
        .LEN_W (LEN_W),
        .CHUNK (CHUNK)
    ) u_pointer (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .frame_len  (req_len),
        .rewind     (rewind),
        .step       (step),
        .rd_ptr     (buf_addr),
        .chunk_last (chunk_last),
        .frame_last (frame_last),
        .more_left  (more_left)
    );

    txf_sequencer #(
        .LEN_W   (LEN_W),
        .MAX_LEN (MAX_LEN)
    ) u_sequencer (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_len     (req_len),
        .line_active (line_active),
        .pool_ready  (pool_ready),
        .underrun    (underrun),
        .repeat_req  (repeat_req),
        .chunk_last  (chunk_last),
        .frame_last  (frame_last),
        .more_left   (more_left),
        .req_ready   (req_ready),
        .start       (start),
        .step        (step),
        .rewind      (rewind),
        .cmd_req     (cmd_req),
        .confirm     (confirm)
    );

    txf_cmd_encoder u_cmd (
        .cmd_req   (cmd_req),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code)
    );

    assign fifo_wr   = step;
    assign fifo_data = buf_data;

endmodule

// File: rtl/hdlc_txf_check.sv
module hdlc_txf_check #(
    parameter int CHUNK = 32,
    parameter int LEN_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             line_active,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic             req_ready,
    input logic             pool_ready,
    input logic             fifo_wr,
    input logic             cmd_valid,
    input logic [7:0]       cmd_code,
    input logic             confirm
);
    localparam int WC_W = $clog2(CHUNK + 1) + 1;

    logic [WC_W-1:0] writes_since_cmd;

    always_ff @(posedge clk) begin
        if (rst)            writes_since_cmd <= '0;
        else if (cmd_valid) writes_since_cmd <= '0;
        else if (fifo_wr)   writes_since_cmd <= writes_since_cmd + 1'b1;
    end

    a_r1_init_command: assert property (@(posedge clk)
        $fell(rst) |-> (cmd_valid && cmd_code == 8'h41 && !req_ready));

    a_r2_idle_is_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!fifo_wr && !cmd_valid));

    a_r3_drop_inactive: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !line_active) |=> (!fifo_wr && req_ready));

    a_r4_drop_zero_len: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_len == '0) |=> (!fifo_wr && req_ready));

    a_r5_chunk_limit: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> (writes_since_cmd < WC_W'(CHUNK)));

    a_r5_write_cmd_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fifo_wr && cmd_valid));

    a_r6_code_legal: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_code == 8'h08 || cmd_code == 8'h0A || cmd_code == 8'h41));

    a_r8_confirm_follows_pool: assert property (@(posedge clk) disable iff (rst)
        confirm |-> ($past(pool_ready) && req_ready));

    a_r8_confirm_single: assert property (@(posedge clk) disable iff (rst)
        confirm |=> !confirm);

endmodule

bind hdlc_tx_feeder hdlc_txf_check #(
    .CHUNK (CHUNK),
    .LEN_W (LEN_W)
) u_check (
    .clk         (clk),
    .rst         (rst),
    .line_active (line_active),
    .req_valid   (req_valid),
    .req_len     (req_len),
    .req_ready   (req_ready),
    .pool_ready  (pool_ready),
    .fifo_wr     (fifo_wr),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .confirm     (confirm)
);

// File: tb/hdlc_tx_feeder_test.sv
`timescale 1ns/1ps
module hdlc_tx_feeder_test;
    localparam int CHUNK   = 32;
    localparam int MAX_LEN = 300;
    localparam int LEN_W   = 9;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             line_active = 1'b1;
    logic             req_valid = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic             req_ready;
    logic [LEN_W-1:0] buf_addr;
    logic [7:0]       buf_data;
    logic             pool_ready = 1'b0;
    logic             underrun = 1'b0;
    logic             repeat_req = 1'b0;
    logic             fifo_wr;
    logic [7:0]       fifo_data;
    logic             cmd_valid;
    logic [7:0]       cmd_code;
    logic             confirm;

    logic [7:0] mem [0:511];
    logic [7:0] wr_log [0:1023];
    logic [7:0] cmd_log [0:63];
    int wr_n = 0;
    int cmd_n = 0;
    int conf_n = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign buf_data = mem[buf_addr];

    hdlc_tx_feeder #(.CHUNK(CHUNK), .MAX_LEN(MAX_LEN), .DATA_W(8), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst(rst), .line_active(line_active),
        .req_valid(req_valid), .req_len(req_len), .req_ready(req_ready),
        .buf_addr(buf_addr), .buf_data(buf_data),
        .pool_ready(pool_ready), .underrun(underrun), .repeat_req(repeat_req),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .confirm(confirm)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (fifo_wr && wr_n < 1024) begin
                wr_log[wr_n] = fifo_data;
                wr_n = wr_n + 1;
            end
            if (cmd_valid && cmd_n < 64) begin
                cmd_log[cmd_n] = cmd_code;
                cmd_n = cmd_n + 1;
            end
            if (confirm) conf_n = conf_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_code(input int len, input int j);
        return ((len - CHUNK * j) <= CHUNK) ? 8'h0A : 8'h08;
    endfunction

    task automatic clear_logs();
        wr_n = 0;
        cmd_n = 0;
        conf_n = 0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        idle_cycles(3);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(cmd_valid == 1'b1, "R1", "init strobe", int'(cmd_valid), 1);
        check(cmd_code == 8'h41, "R1", "init code", int'(cmd_code), 8'h41);
        check(req_ready == 1'b0, "R1", "ready during init", int'(req_ready), 0);
        idle_cycles(2);
        check(req_ready == 1'b1, "R2", "ready after init", int'(req_ready), 1);
        check(cmd_n == 1, "R1", "commands after reset", cmd_n, 1);
        check(wr_n == 0, "R1", "writes after reset", wr_n, 0);
    endtask

    task automatic t_idle_events();
        clear_logs();
        @(negedge clk) pool_ready = 1'b1;
        @(negedge clk) begin pool_ready = 1'b0; underrun = 1'b1; end
        @(negedge clk) begin underrun = 1'b0; repeat_req = 1'b1; end
        @(negedge clk) repeat_req = 1'b0;
        idle_cycles(3);
        check(wr_n == 0, "R10", "idle event writes", wr_n, 0);
        check(cmd_n == 0, "R10", "idle event commands", cmd_n, 0);
        check(conf_n == 0, "R10", "idle event confirms", conf_n, 0);
        check(req_ready == 1'b1, "R10", "ready after idle events", int'(req_ready), 1);
    endtask

    task automatic t_drop(input int len, input bit line, input string tag);
        clear_logs();
        line_active = line;
        @(negedge clk) begin req_valid = 1'b1; req_len = LEN_W'(len); end
        @(negedge clk) req_valid = 1'b0;
        check(req_ready == 1'b1, tag, "ready after dropped request", int'(req_ready), 1);
        @(negedge clk) pool_ready = 1'b1;
        @(negedge clk) pool_ready = 1'b0;
        idle_cycles(4);
        check(wr_n == 0, tag, "dropped request writes", wr_n, 0);
        check(cmd_n == 0, tag, "dropped request commands", cmd_n, 0);
        check(conf_n == 0, tag, "dropped request confirms", conf_n, 0);
        line_active = 1'b1;
    endtask

    // kind: 0 none, 1 underrun, 2 repeat request, 3 underrun with pool-ready in the same cycle
    task automatic run_frame(input int len, input int k, input int kind,
                             input bit poke, input string tag);
        logic [7:0] exp_b [0:1023];
        logic [7:0] exp_c [0:63];
        int exp_n = 0;
        int exp_cn = 0;
        int prefix = 0;
        int seen = 0;
        int guard = 0;
        int bad = -1;
        int badc = -1;
        bit rew = 1'b0;

        if (kind != 0) begin
            prefix = (CHUNK * k < len) ? CHUNK * k : len;
            for (int j = 0; j < k; j++) begin
                exp_c[exp_cn] = exp_code(len, j);
                exp_cn++;
            end
        end
        for (int i = 0; i < prefix; i++) begin
            exp_b[exp_n] = mem[i];
            exp_n++;
        end
        for (int i = 0; i < len; i++) begin
            exp_b[exp_n] = mem[i];
            exp_n++;
        end
        for (int j = 0; j < (len + CHUNK - 1) / CHUNK; j++) begin
            exp_c[exp_cn] = exp_code(len, j);
            exp_cn++;
        end

        clear_logs();
        @(negedge clk) begin req_valid = 1'b1; req_len = LEN_W'(len); end
        @(negedge clk) req_valid = 1'b0;
        check(req_ready == 1'b0, "R2", {tag, " ready while busy"}, int'(req_ready), 0);

        while (conf_n == 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (cmd_n > seen) begin
                seen = cmd_n;
                @(negedge clk);
                if (kind != 0 && !rew && seen == k) begin
                    rew = 1'b1;
                    if (kind == 3) begin
                        underrun = 1'b1;
                        pool_ready = 1'b1;
                        @(negedge clk) begin underrun = 1'b0; pool_ready = 1'b0; end
                    end else begin
                        if (kind == 1) underrun = 1'b1;
                        else repeat_req = 1'b1;
                        @(negedge clk) begin underrun = 1'b0; repeat_req = 1'b0; end
                        idle_cycles(2);
                        pool_ready = 1'b1;
                        @(negedge clk) pool_ready = 1'b0;
                    end
                end else begin
                    if (poke && seen == 1) begin
                        req_valid = 1'b1;
                        req_len = LEN_W'(3);
                        check(req_ready == 1'b0, "R2", {tag, " refuse busy request"},
                              int'(req_ready), 0);
                    end
                    pool_ready = 1'b1;
                    @(negedge clk) begin pool_ready = 1'b0; req_valid = 1'b0; end
                end
            end
        end
        idle_cycles(4);

        for (int i = 0; i < exp_n && i < wr_n; i++)
            if (bad < 0 && wr_log[i] !== exp_b[i]) bad = i;
        for (int j = 0; j < exp_cn && j < cmd_n; j++)
            if (badc < 0 && cmd_log[j] !== exp_c[j]) badc = j;

        check(wr_n == exp_n, "R5", {tag, " byte count"}, wr_n, exp_n);
        if (bad >= 0)
            check(1'b0, (kind != 0) ? "R9" : "R5", {tag, " byte value"},
                  int'(wr_log[bad]), int'(exp_b[bad]));
        else
            check(1'b1, "R5", {tag, " byte value"}, 0, 0);
        check(cmd_n == exp_cn, "R6", {tag, " command count"}, cmd_n, exp_cn);
        if (badc >= 0)
            check(1'b0, "R6", {tag, " command code"}, int'(cmd_log[badc]), int'(exp_c[badc]));
        else
            check(1'b1, "R6", {tag, " command code"}, 0, 0);
        check(conf_n == 1, "R8", {tag, " confirm count"}, conf_n, 1);
        check(req_ready == 1'b1, "R8", {tag, " ready after confirm"}, int'(req_ready), 1);
    endtask

    initial begin
        #500000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));

        t_reset();
        t_idle_events();
        t_drop(40, 1'b0, "R3");
        t_drop(0, 1'b1, "R4");
        t_drop(301, 1'b1, "R4");

        run_frame(1,   0, 0, 1'b0, "R7 len1");
        run_frame(32,  0, 0, 1'b0, "R6 len32");
        run_frame(33,  0, 0, 1'b0, "R6 len33");
        run_frame(64,  0, 0, 1'b0, "R7 len64");
        run_frame(300, 0, 0, 1'b0, "R4 len300");
        run_frame(50,  0, 0, 1'b1, "R2 poke");
        run_frame(70,  1, 1, 1'b0, "R9 underrun");
        run_frame(100, 2, 2, 1'b0, "R9 repeat");
        run_frame(40,  1, 3, 1'b0, "R9 same cycle");
        run_frame(20,  1, 1, 1'b0, "R9 after last");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule